// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is the 8-bit status register of one channel of a multi-channel 16-bit timer. It sits beside the channel's up/down counter. On every count step it sees the value the counter held before the step and the direction of the step. From these it tracks the count direction and detects wraparound. On overflow or underflow it sets a sticky flag, and the flag stays set until software clears it.

Software reads and writes the register over a single-cycle register bus. A flag clears only through a handshake: a bus read must first return the flag as 1, and then a write must put 0 in that bit. Any write uses up the pending read, whatever data it carries. The parameter `CH_IDX` selects which bits the channel implements. Channel 0 has no direction bit. Only channels 1 and 2 have an underflow flag. Only channel 4 also treats a downward step from 0x0001 as an overflow in complementary-PWM mode.

Top module: `tsr_status_reg`

## Requirements
- R1: After reset every channel reads 0xC0: bit 7 = 1, bit 6 = 1, bit 5 = 0, bit 4 = 0, bits 3:0 = 0.
- R2: On channels 1 to 4, bit 7 shows the direction of the most recent count step (1 up, 0 down). It holds its value between steps.
- R3: On channel 0, bit 7 always reads 1. On every channel, bit 6 reads 1 and bits 3:0 read 0. Writes never change these bits.
- R4: An upward step taken from 0xFFFF sets the overflow flag in bit 4.
- R5: On channels 1 and 2, with mode_i = 2'b01 (phase counting), a downward step taken from 0x0000 sets the underflow flag in bit 5. In any other mode, and on any other channel, bit 5 reads 0.
- R6: On channel 4, with mode_i = 2'b10 (complementary PWM), a downward step taken from 0x0001 sets bit 4. The same step in another mode does not.
- R7: A write of 0 to a flag bit clears that flag only if a read since the last write returned the flag as 1. Without such a read, the write leaves the flag unchanged.
- R8: Writing 1 to a flag bit never clears it. Every write cancels all pending read qualifications, so a later write of 0 needs a fresh read.
- R9: If a set event and a qualified clearing write fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | The counter takes a step this cycle |
| dir_up_i | input | 1 | Step direction: 1 up, 0 down |
| cnt_i | input | 16 | Counter value before the step |
| mode_i | input | 2 | 00 normal, 01 phase counting, 10 complementary PWM, 11 normal |
| bus_en_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Register contents, valid combinationally |

## Verification
The bench checks three instances side by side: channels 0, 2 and 4. Together they cover the absent direction bit, the channel with an underflow flag and the channel with the extra overflow condition, so a design that decodes the channel index wrongly shows a mismatch on at least one of them. The handshake tests cover several wrong implementations. A write of 0 with no prior read must leave the flag set, which catches a design with no qualification at all. A write of 1 followed by a write of 0 must also leave the flag set, which catches a design whose read qualification is not consumed by every write. A clearing write issued in the same cycle as a wrap must leave the flag set, which catches a design where the clear has priority over the set. Steps from 0x0000 and 0x0001 are repeated in the wrong mode to catch set conditions that do not depend on the mode.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CPWM   = 2'b10,
    MODE_RSVD   = 2'b11
  } tsr_mode_e;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned DIR_BIT = 7;
  localparam int unsigned ONE_BIT = 6;
  localparam int unsigned UDF_BIT = 5;
  localparam int unsigned OVF_BIT = 4;
endpackage

// File: rtl/tsr_wrap_det.sv
module tsr_wrap_det #(
  parameter int unsigned CNT_W    = 16,
  parameter bit          UDF_EN   = 1'b0,
  parameter bit          CPWM_OVF = 1'b0
) (
  input  logic             step_i,
  input  logic             dir_up_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       mode_i,
  output logic             ovf_set_o,
  output logic             udf_set_o
);
  import tsr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic up_wrap, dn_wrap, cpwm_hit;

  assign up_wrap = step_i &&  dir_up_i && (cnt_i == CNT_MAX);
  assign dn_wrap = step_i && !dir_up_i && (cnt_i == '0);

  generate
    if (CPWM_OVF) begin : g_cpwm
      assign cpwm_hit = step_i && !dir_up_i && (cnt_i == CNT_ONE) &&
                        (tsr_mode_e'(mode_i) == MODE_CPWM);
    end else begin : g_no_cpwm
      assign cpwm_hit = 1'b0;
    end
    if (UDF_EN) begin : g_udf
      assign udf_set_o = dn_wrap && (tsr_mode_e'(mode_i) == MODE_PHASE);
    end else begin : g_no_udf
      assign udf_set_o = 1'b0;
    end
  endgenerate

  assign ovf_set_o = up_wrap || cpwm_hit;
endmodule

// File: rtl/tsr_sticky_flag.sv
module tsr_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  // arm: flag was seen as 1 by a read; any write uses it up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else if (wr_i) begin
      arm_q <= 1'b0;
    end else if (rd_i && flag_q) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (wr_i && arm_q && !wbit_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  // R7
  qual_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(arm_q) && $past(wr_i) && !$past(wbit_i)));
endmodule

// File: rtl/tsr_dir_track.sv
module tsr_dir_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_up_i,
  output logic dir_o
);
  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= 1'b1;
    else if (step_i) dir_q <= dir_up_i;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/tsr_status_reg.sv
module tsr_status_reg #(
  parameter int unsigned CH_IDX = 1,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_up_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       mode_i,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o
);
  import tsr_pkg::*;

  localparam bit HAS_DIR  = (CH_IDX != 0);
  localparam bit HAS_UDF  = (CH_IDX == 1) || (CH_IDX == 2);
  localparam bit CPWM_OVF = (CH_IDX == 4);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic rd, wr;
  logic ovf_set, udf_set;
  logic ovf_bit, udf_bit, dir_bit, dir_raw;
  logic unused_sink;

  assign rd = bus_en_i && !bus_we_i;
  assign wr = bus_en_i &&  bus_we_i;

  tsr_wrap_det #(
    .CNT_W   (CNT_W),
    .UDF_EN  (HAS_UDF),
    .CPWM_OVF(CPWM_OVF)
  ) wrap_i (
    .step_i   (step_i),
    .dir_up_i (dir_up_i),
    .cnt_i    (cnt_i),
    .mode_i   (mode_i),
    .ovf_set_o(ovf_set),
    .udf_set_o(udf_set)
  );

  tsr_dir_track dir_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .dir_up_i(dir_up_i),
    .dir_o   (dir_raw)
  );

  tsr_sticky_flag ovf_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ovf_set),
    .rd_i  (rd),
    .wr_i  (wr),
    .wbit_i(bus_wdata_i[OVF_BIT]),
    .flag_o(ovf_bit)
  );

  generate
    if (HAS_UDF) begin : g_udf
      tsr_sticky_flag udf_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (udf_set),
        .rd_i  (rd),
        .wr_i  (wr),
        .wbit_i(bus_wdata_i[UDF_BIT]),
        .flag_o(udf_bit)
      );
    end else begin : g_no_udf
      assign udf_bit = 1'b0;
    end
    if (HAS_DIR) begin : g_dir
      assign dir_bit = dir_raw;
    end else begin : g_no_dir
      assign dir_bit = 1'b1;
    end
  endgenerate

  assign unused_sink = ^{bus_wdata_i[7:6], bus_wdata_i[3:0], udf_set, dir_raw};

  always_comb begin
    bus_rdata_o          = '0;
    bus_rdata_o[DIR_BIT] = dir_bit;
    bus_rdata_o[ONE_BIT] = 1'b1;
    bus_rdata_o[UDF_BIT] = udf_bit;
    bus_rdata_o[OVF_BIT] = ovf_bit;
  end

  // R2
  dir_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (bus_rdata_o[7] == (HAS_DIR ? $past(dir_up_i) : 1'b1)));

  // R4
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_up_i && cnt_i == CNT_MAX) |=> bus_rdata_o[4]);

  // R5
  udf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_UDF && step_i && !dir_up_i && cnt_i == '0 && mode_i == 2'b01)
      |=> bus_rdata_o[5]);
endmodule

// File: tb/tsr_status_reg_tb.sv
`timescale 1ns/1ps
module tsr_status_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic        dir_up_i = 1'b1;
  logic [15:0] cnt_i = '0;
  logic [1:0]  mode_i = 2'b00;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  rd0, rd2, rd4;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] e0;
    logic [7:0] e2;
    logic [7:0] e4;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  tsr_status_reg #(.CH_IDX(0)) dut_i (
    .clk_i, .rst_ni, .step_i, .dir_up_i, .cnt_i, .mode_i,
    .bus_en_i, .bus_we_i, .bus_wdata_i, .bus_rdata_o(rd0));
  tsr_status_reg #(.CH_IDX(2)) dut2_i (
    .clk_i, .rst_ni, .step_i, .dir_up_i, .cnt_i, .mode_i,
    .bus_en_i, .bus_we_i, .bus_wdata_i, .bus_rdata_o(rd2));
  tsr_status_reg #(.CH_IDX(4)) dut4_i (
    .clk_i, .rst_ni, .step_i, .dir_up_i, .cnt_i, .mode_i,
    .bus_en_i, .bus_we_i, .bus_wdata_i, .bus_rdata_o(rd4));

  task automatic cmp(input string ch, input logic [7:0] act,
                     input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%s: got %02h expected %02h", req, ch, act, exp);
    end
  endtask

  // monitor: compares every read cycle against the scoreboard
  always @(negedge clk_i) begin
    #1;
    if (bus_en_i && !bus_we_i) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL monitor: read with empty scoreboard");
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        cmp("0", rd0, it.e0, it.req);
        cmp("2", rd2, it.e2, it.req);
        cmp("4", rd4, it.e4, it.req);
      end
    end
  end

  task automatic do_read(input logic [7:0] e0, input logic [7:0] e2,
                         input logic [7:0] e4, input string req);
    exp_t it;
    it.e0 = e0; it.e2 = e2; it.e4 = e4; it.req = req;
    sb_q.push_back(it);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b0;
    @(negedge clk_i);
    bus_en_i = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic do_step(input logic up, input logic [15:0] c,
                         input logic [1:0] m, input bit with_wr0);
    @(negedge clk_i);
    step_i = 1'b1; dir_up_i = up; cnt_i = c; mode_i = m;
    if (with_wr0) begin
      bus_en_i = 1'b1; bus_we_i = 1'b1; bus_wdata_i = 8'h00;
    end
    @(negedge clk_i);
    step_i = 1'b0; bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    do_read(8'hC0, 8'hC0, 8'hC0, "R1");
    do_step(1'b1, 16'hFFFF, 2'b00, 1'b0);
    do_write(8'h00);                          // no prior read
    do_read(8'hD0, 8'hD0, 8'hD0, "R4_R7");
    do_write(8'hFF);                          // consumes qualification
    do_write(8'h00);
    do_read(8'hD0, 8'hD0, 8'hD0, "R8");
    do_write(8'hEF);                          // qualified clear of bit 4
    do_read(8'hC0, 8'hC0, 8'hC0, "R7_R3");
    do_step(1'b0, 16'h0000, 2'b01, 1'b0);
    do_read(8'hC0, 8'h60, 8'h40, "R5_R2");
    do_write(8'h00);
    do_read(8'hC0, 8'h40, 8'h40, "R7_R3");
    do_step(1'b0, 16'h0000, 2'b00, 1'b0);
    do_read(8'hC0, 8'h40, 8'h40, "R5");
    do_step(1'b0, 16'h0001, 2'b00, 1'b0);
    do_read(8'hC0, 8'h40, 8'h40, "R6");
    do_step(1'b0, 16'h0001, 2'b10, 1'b0);
    do_read(8'hC0, 8'h40, 8'h50, "R6");
    do_step(1'b1, 16'hFFFF, 2'b00, 1'b1);     // set and clear together
    do_read(8'hD0, 8'hD0, 8'hD0, "R9_R2");
    do_step(1'b1, 16'h1234, 2'b00, 1'b0);
    do_read(8'hD0, 8'hD0, 8'hD0, "R2");
    repeat (2) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads never observed", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule